// File: doc/BRIEF.md
# Dual-Issue Typed Slot Packer

This block sits between instruction decode and a statically scheduled two-wide issue stage. It takes decoded instructions one at a time, in program order. Each instruction carries a two-bit class and an opcode. Every packet it emits has two typed lanes. The arithmetic lane takes an ALU or branch operation. The memory lane takes a load or store.

Two neighbouring instructions share a packet only when the pairing is legal:
- an ALU operation followed by a memory operation, or
- a memory operation followed by a branch. The branch ends the packet.

Any other neighbour starts a new packet. A lane that has nothing legal to carry receives a NOP.

Both edges use valid/ready handshakes. Inside the block a two-state controller manages a one-entry holding buffer:

- `ST_EMPTY`: the buffer holds nothing.
- `ST_HELD`: the buffer holds the oldest instruction not yet issued.

The controller has four named transitions:

- `T_FILL`: `ST_EMPTY` to `ST_HELD`. An instruction is accepted into the buffer.
- `T_PAIR`: `ST_HELD` to `ST_EMPTY`. The held and incoming instructions leave together.
- `T_SHIFT`: `ST_HELD` to `ST_HELD`. The held instruction leaves alone and the incoming one takes its place.
- `T_FLUSH`: `ST_HELD` to `ST_EMPTY`. The held instruction leaves alone because nothing was offered.

The output packet is registered. While the packet output is blocked, nothing moves.

Top module: `dual_issue_packer`

## Requirements
- R1: A synchronous active-high `rst` leaves `out_valid` low, both lanes as NOP (fill bit 0, opcode 0, flag 0) and `in_ready` high.
- R2: The class encoding is 00 ALU, 01 branch, 10 load, 11 store. ALU and branch go only to the arithmetic lane, with `alu_br` high for a branch. Loads and stores go only to the memory lane, with `mem_st` high for a store.
- R3: An ALU instruction immediately followed by a load or store leaves in one packet.
- R4: A load or store immediately followed by a branch leaves in one packet, and the branch closes it.
- R5: For every other pair of neighbours, the older instruction leaves alone and the other lane is NOP.
- R6: A NOP lane has its fill bit and opcode at zero. A valid packet never has both lanes NOP.
- R7: A held instruction with no instruction offered in a cycle where the output can load is issued alone in that cycle. It does not wait for a partner.
- R8: While `out_valid` is high and `out_ready` is low, the packet holds steady and `in_ready` is low unless the buffer is empty. No instruction is lost or issued twice.
- R9: Packets leave in program order, and within each packet the instructions keep their relative order.
- R10: With the buffer empty, `in_ready` is high whatever `out_ready` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_cls | input | 2 | Instruction class (00 ALU, 01 branch, 10 load, 11 store) |
| in_op | input | OPW | Instruction opcode |
| out_valid | output | 1 | Packet valid |
| out_ready | input | 1 | Issue stage takes the packet |
| alu_fill | output | 1 | Arithmetic lane holds a real instruction |
| alu_op | output | OPW | Arithmetic lane opcode (zero for NOP) |
| alu_br | output | 1 | Arithmetic lane instruction is a branch |
| mem_fill | output | 1 | Memory lane holds a real instruction |
| mem_op | output | OPW | Memory lane opcode (zero for NOP) |
| mem_st | output | 1 | Memory lane instruction is a store |

## Verification
A wrong controller state or a stale holding buffer shows at the ports within one or two packets. Typical symptoms are:
- a packet that splits a legal pair or joins an illegal one;
- a repeated opcode, or one that goes missing;
- `in_ready` that disagrees with the buffer occupancy;
- a packet that changes while it is stalled.

Every three-instruction class sequence is driven twice, once with the output always ready and once under periodic back-pressure. Each packet is compared against a greedy pairing computed from the class rules. After each sequence the bench checks that no further packet appears and that the buffer reports empty.

// File: rtl/dual_issue_packer_pkg.sv
package dual_issue_packer_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_BR  = 2'b01,
        CLS_LD  = 2'b10,
        CLS_ST  = 2'b11
    } instr_cls_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } pack_state_e;

    function automatic logic cls_is_mem(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/dip_pair_rule.sv
module dip_pair_rule
    import dual_issue_packer_pkg::*;
(
    input  logic [1:0] head_cls,
    input  logic       next_vld,
    input  logic [1:0] next_cls,
    output logic       pair_ok,
    output logic       head_mem
);

    logic alu_then_mem;
    logic mem_then_br;

    always_comb begin
        head_mem     = cls_is_mem(head_cls);
        // ALU first, memory op second: both lanes filled in order
        alu_then_mem = (head_cls == CLS_ALU) && cls_is_mem(next_cls);
        // memory op first, branch second: branch closes the packet
        mem_then_br  = cls_is_mem(head_cls) && (next_cls == CLS_BR);
        pair_ok      = next_vld && (alu_then_mem || mem_then_br);
    end

endmodule

// File: rtl/dip_pkt_reg.sv
module dip_pkt_reg #(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           out_ready,
    input  logic           s0_fill,
    input  logic [OPW-1:0] s0_op,
    input  logic           s0_br,
    input  logic           s1_fill,
    input  logic [OPW-1:0] s1_op,
    input  logic           s1_st,
    output logic           out_valid,
    output logic           alu_fill,
    output logic [OPW-1:0] alu_op,
    output logic           alu_br,
    output logic           mem_fill,
    output logic [OPW-1:0] mem_op,
    output logic           mem_st
);

    localparam int LANEW = OPW + 2;

    logic [LANEW-1:0] lane0_q;
    logic [LANEW-1:0] lane1_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            lane0_q <= '0;
            lane1_q <= '0;
        end else if (load) begin
            vld_q   <= 1'b1;
            lane0_q <= {s0_fill, s0_br, s0_op};
            lane1_q <= {s1_fill, s1_st, s1_op};
        end else if (out_ready) begin
            vld_q   <= 1'b0;
            lane0_q <= '0;
            lane1_q <= '0;
        end
    end

    always_comb begin
        out_valid = vld_q;
        alu_fill  = lane0_q[LANEW-1];
        alu_br    = lane0_q[LANEW-2];
        alu_op    = lane0_q[OPW-1:0];
        mem_fill  = lane1_q[LANEW-1];
        mem_st    = lane1_q[LANEW-2];
        mem_op    = lane1_q[OPW-1:0];
    end

endmodule

// File: rtl/dual_issue_packer.sv
module dual_issue_packer
    import dual_issue_packer_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [1:0]     in_cls,
    input  logic [OPW-1:0] in_op,
    output logic           out_valid,
    input  logic           out_ready,
    output logic           alu_fill,
    output logic [OPW-1:0] alu_op,
    output logic           alu_br,
    output logic           mem_fill,
    output logic [OPW-1:0] mem_op,
    output logic           mem_st
);

    pack_state_e    state_q, state_d;
    logic [1:0]     held_cls;
    logic [OPW-1:0] held_op;
    logic           can_load;
    logic           buf_load;
    logic           pkt_load;
    logic           pair_ok;
    logic           head_mem;
    logic           take_pair;

    logic           s0_fill, s0_br, s1_fill, s1_st;
    logic [OPW-1:0] s0_op, s1_op;

    assign can_load = !out_valid || out_ready;

    dip_pair_rule i_rule (
        .head_cls (held_cls),
        .next_vld (in_valid),
        .next_cls (in_cls),
        .pair_ok  (pair_ok),
        .head_mem (head_mem)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // holding buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            held_cls <= '0;
            held_op  <= '0;
        end else if (buf_load) begin
            held_cls <= in_cls;
            held_op  <= in_op;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        buf_load  = 1'b0;
        pkt_load  = 1'b0;
        take_pair = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) begin          // T_FILL
                    buf_load = 1'b1;
                    state_d  = ST_HELD;
                end
            end
            ST_HELD: begin
                in_ready = can_load;
                if (can_load) begin
                    pkt_load = 1'b1;
                    if (pair_ok) begin       // T_PAIR
                        take_pair = 1'b1;
                        state_d   = ST_EMPTY;
                    end else if (in_valid) begin  // T_SHIFT
                        buf_load = 1'b1;
                        state_d  = ST_HELD;
                    end else begin           // T_FLUSH
                        state_d = ST_EMPTY;
                    end
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // lane contents
    always_comb begin
        s0_fill = 1'b0;
        s0_op   = '0;
        s0_br   = 1'b0;
        s1_fill = 1'b0;
        s1_op   = '0;
        s1_st   = 1'b0;
        if (head_mem) begin
            s1_fill = 1'b1;
            s1_op   = held_op;
            s1_st   = (held_cls == CLS_ST);
            if (take_pair) begin
                s0_fill = 1'b1;
                s0_op   = in_op;
                s0_br   = 1'b1;
            end
        end else begin
            s0_fill = 1'b1;
            s0_op   = held_op;
            s0_br   = (held_cls == CLS_BR);
            if (take_pair) begin
                s1_fill = 1'b1;
                s1_op   = in_op;
                s1_st   = (in_cls == CLS_ST);
            end
        end
    end

    dip_pkt_reg #(.OPW(OPW)) i_pkt (
        .clk       (clk),
        .rst       (rst),
        .load      (pkt_load),
        .out_ready (out_ready),
        .s0_fill   (s0_fill),
        .s0_op     (s0_op),
        .s0_br     (s0_br),
        .s1_fill   (s1_fill),
        .s1_op     (s1_op),
        .s1_st     (s1_st),
        .out_valid (out_valid),
        .alu_fill  (alu_fill),
        .alu_op    (alu_op),
        .alu_br    (alu_br),
        .mem_fill  (mem_fill),
        .mem_op    (mem_op),
        .mem_st    (mem_st)
    );

endmodule

// File: rtl/dual_issue_packer_sva.sv
module dual_issue_packer_sva #(
    parameter int OPW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic           alu_fill,
    input logic [OPW-1:0] alu_op,
    input logic           alu_br,
    input logic           mem_fill,
    input logic [OPW-1:0] mem_op,
    input logic           mem_st
);

    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(alu_op) && $stable(mem_op)
            && $stable(alu_fill) && $stable(mem_fill) && $stable(alu_br) && $stable(mem_st))); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && out_valid && !out_ready) |=> (out_ready || !in_ready)); // R8

    AST_ALU_NOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !alu_fill |-> (alu_op == '0 && !alu_br)); // R6

    AST_MEM_NOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mem_fill |-> (mem_op == '0 && !mem_st)); // R6

    AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (alu_fill || mem_fill)); // R6

endmodule

bind dual_issue_packer dual_issue_packer_sva #(.OPW(OPW)) i_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .alu_fill  (alu_fill),
    .alu_op    (alu_op),
    .alu_br    (alu_br),
    .mem_fill  (mem_fill),
    .mem_op    (mem_op),
    .mem_st    (mem_st)
);

// File: tb/test_dual_issue_packer.sv
module test_dual_issue_packer;

    localparam int OPW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [1:0]     in_cls = '0;
    logic [OPW-1:0] in_op = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic           alu_fill, alu_br, mem_fill, mem_st;
    logic [OPW-1:0] alu_op, mem_op;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_issue_packer #(.OPW(OPW)) i_dual_issue_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
        .alu_fill(alu_fill), .alu_op(alu_op), .alu_br(alu_br),
        .mem_fill(mem_fill), .mem_op(mem_op), .mem_st(mem_st)
    );

    // sequence under test and expected packets
    logic [1:0]     sq_cls [3];
    logic [OPW-1:0] sq_op  [3];
    logic [OPW+1:0] ex_l0  [4];  // {fill, br, op}
    logic [OPW+1:0] ex_l1  [4];  // {fill, st, op}
    string          ex_tag [4];
    int             n_exp;

    function automatic logic is_mem(input logic [1:0] c);
        return c[1];
    endfunction

    function automatic logic can_pair(input logic [1:0] a, input logic [1:0] b);
        return (a == 2'b00 && is_mem(b)) || (is_mem(a) && b == 2'b01);
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // greedy pairing computed from the class rules (R3, R4, R5, R7)
    task automatic build_expect();
        int i = 0;
        n_exp = 0;
        while (i < 3) begin
            ex_l0[n_exp] = '0;
            ex_l1[n_exp] = '0;
            if (i < 2 && can_pair(sq_cls[i], sq_cls[i+1])) begin
                if (sq_cls[i] == 2'b00) begin
                    ex_l0[n_exp] = {1'b1, 1'b0, sq_op[i]};
                    ex_l1[n_exp] = {1'b1, sq_cls[i+1] == 2'b11, sq_op[i+1]};
                    ex_tag[n_exp] = "R3";
                end else begin
                    ex_l0[n_exp] = {1'b1, 1'b1, sq_op[i+1]};
                    ex_l1[n_exp] = {1'b1, sq_cls[i] == 2'b11, sq_op[i]};
                    ex_tag[n_exp] = "R4";
                end
                i += 2;
            end else begin
                if (is_mem(sq_cls[i])) ex_l1[n_exp] = {1'b1, sq_cls[i] == 2'b11, sq_op[i]};
                else                   ex_l0[n_exp] = {1'b1, sq_cls[i] == 2'b01, sq_op[i]};
                ex_tag[n_exp] = (i == 2) ? "R7" : "R5";
                i += 1;
            end
            n_exp++;
        end
    endtask

    task automatic run_seq(input int bp);
        int idx = 0;
        int eidx = 0;
        int cyc = 0;
        logic stalled = 1'b0;
        logic [2*OPW+3:0] saved = '0;
        logic [2*OPW+3:0] now_pkt;
        build_expect();
        while (eidx < n_exp && cyc < 60) begin
            @(negedge clk);
            out_ready = (bp == 0) ? 1'b1 : (cyc % 3 != 0);
            if (idx < 3) begin
                in_valid = 1'b1; in_cls = sq_cls[idx]; in_op = sq_op[idx];
            end else begin
                in_valid = 1'b0; in_cls = '0; in_op = '0;
            end
            #1;
            now_pkt = {alu_fill, alu_br, alu_op, mem_fill, mem_st, mem_op};
            if (stalled)
                check(out_valid && now_pkt == saved, "R8", "stalled packet changed",
                      32'(now_pkt), 32'(saved));
            if (out_valid && out_ready) begin
                // lane typing R2, NOP form R6, order R9
                check({alu_fill, alu_br, alu_op} == ex_l0[eidx], ex_tag[eidx],
                      "arith lane (R2 R6 R9)", 32'({alu_fill, alu_br, alu_op}), 32'(ex_l0[eidx]));
                check({mem_fill, mem_st, mem_op} == ex_l1[eidx], ex_tag[eidx],
                      "memory lane (R2 R6 R9)", 32'({mem_fill, mem_st, mem_op}), 32'(ex_l1[eidx]));
                eidx++;
            end
            stalled = out_valid && !out_ready;
            saved   = now_pkt;
            if (in_valid && in_ready) idx++;
            cyc++;
        end
        check(eidx == n_exp, "R8", "packets delivered", 32'(eidx), 32'(n_exp));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_cls = '0; in_op = '0;
            out_ready = (k == 1) ? 1'b0 : 1'b1;
            #1;
            check(!out_valid, "R8", "extra packet after drain", 32'(out_valid), 32'd0);
            check(in_ready, "R10", "buffer empty ready", 32'(in_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check(!alu_fill && alu_op == '0 && !alu_br, "R1", "arith lane NOP",
              32'({alu_fill, alu_br, alu_op}), 32'd0);
        check(!mem_fill && mem_op == '0 && !mem_st, "R1", "memory lane NOP",
              32'({mem_fill, mem_st, mem_op}), 32'd0);
        check(in_ready, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
        rst = 1'b0;
        // R10: empty buffer accepts even when output blocked
        out_ready = 1'b0;
        #1;
        check(in_ready, "R10", "ready while output blocked", 32'(in_ready), 32'd1);
        out_ready = 1'b1;
        for (int bp = 0; bp < 2; bp++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        sq_cls[0] = 2'(a); sq_cls[1] = 2'(b); sq_cls[2] = 2'(c);
                        for (int p = 0; p < 3; p++)
                            sq_op[p] = OPW'((run * 3 + p) % 250 + 1);
                        run_seq(bp);
                        run++;
                    end
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule